// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel that copies data across a single 32-bit memory bus. It can run one buffer whose addresses and control words are handed over when it starts, or it can walk a chain of five-word descriptors held in memory. Each descriptor gives a source address, a destination address, two control words and the address of the next descriptor.

For each buffer the channel reads source elements of the selected width and packs them little-endian into a small byte buffer. It then writes destination elements with byte enables. Either address can step by its element width or stay fixed. In chain mode, after each buffer the channel writes the first control word back into the descriptor, with the remaining count and a completion flag. It then either loads the next descriptor or stops. Buffer-done, chain-done and error events are single-cycle pulses. The channel drops `busy` on its own when the work ends or when a bus error occurs.

The start inputs are sampled on a one-cycle `start` pulse while the channel is idle. When peripheral flow is selected, a chunk on that side begins only while that side's request line is high.

Top module: `dma_chain_channel`

## Requirements
- R1: After synchronous reset, `busy`, `mem_req`, `mem_we` and all three event outputs are low.
- R2: A start whose control-B bits 0 and 1 are both set runs a single buffer from the start addresses. It makes no descriptor access and no write-back. When the buffer is done it pulses `evt_buf_done` and `evt_chain_done` together.
- R3: Control-A bits [17:16] select the source width and bits [19:18] the destination width, with 0 = byte, 1 = halfword, 2 = word. Source bytes are packed in ascending address order. Each destination element is written to its own byte lanes, with `mem_be` having exactly 1, 2 or 4 bits set.
- R4: Control-B bit 4 holds the source address fixed and bit 5 holds the destination address fixed. A clear bit makes that address advance by its element width after each beat.
- R5: Control-A bits [CNT_W-1:0] give the buffer length in source elements. A length of zero finishes the buffer with no data access.
- R6: A start with control-B bits 0 and 1 both clear reads five words from `start_dptr`, in this order: source, destination, control A, control B, next. After each buffer, the next descriptor is fetched only if both bits are clear in that descriptor's control B; if either bit is set, that buffer is the last.
- R7: In chain mode, after each buffer the word at descriptor+8 is overwritten with control A, with its count field set to the remaining count (zero) and bit 31 set. One `evt_buf_done` pulse follows each buffer.
- R8: Control-B bits [3:2] select the flow: 0 = memory to memory, 1 = memory to peripheral, 2 = peripheral to memory, 3 = peripheral to peripheral. On a peripheral side, each chunk starts only while `src_req` or `dst_req` is high. The chunk is 4 beats when control-A bit 20 (source) or bit 21 (destination) is set, and 1 beat otherwise.
- R9: A bus response with `mem_err` high ends the transfer. The channel pulses `evt_err`, drops `busy` and `mem_req`, and gives no chain-done pulse.
- R10: `mem_req` is only high while `busy` is high. Once raised, it keeps its address, direction and write data unchanged until `mem_ready` is seen.
- R11: At the end of a transfer, `busy` falls on the same edge that raises `evt_chain_done`, and no request is left pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle enable pulse; sampled when idle |
| start_src | input | ADDR_W | Source address for a single buffer |
| start_dst | input | ADDR_W | Destination address for a single buffer |
| start_ctla | input | 32 | Control A for a single buffer |
| start_ctlb | input | 32 | Control B; bits 0 and 1 choose single or chain start |
| start_dptr | input | ADDR_W | First descriptor address (chain start) |
| src_req | input | 1 | Source peripheral request |
| dst_req | input | 1 | Destination peripheral request |
| mem_req | output | 1 | Bus request valid |
| mem_we | output | 1 | Bus write when high, read when low |
| mem_addr | output | ADDR_W | Word-aligned bus address |
| mem_wdata | output | 32 | Bus write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_ready | input | 1 | Bus accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| mem_err | input | 1 | Error response, valid with `mem_ready` |
| busy | output | 1 | Channel enabled |
| evt_buf_done | output | 1 | Buffer finished pulse |
| evt_chain_done | output | 1 | Whole transfer finished pulse |
| evt_err | output | 1 | Bus error abort pulse |

## Verification
`busy` rises one cycle after `start` is sampled. Each bus request is registered, so it appears one cycle after the decision that issues it. Every event pulse appears on the edge after the last bus acceptance and lines up with the fall of `busy`. The bench drives at falling edges and waits for `busy` to drop. It then waits one more falling edge before reading its event and access counters, because those counters register the pulses one edge later. Idle periods, such as a withheld peripheral request, are checked over a fixed number of cycles by confirming that no bus write or read happened in that window.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int WORD_W = 32;

  // control A field positions
  localparam int CA_SW_LSB = 16;
  localparam int CA_DW_LSB = 18;
  localparam int CA_SCHUNK = 20;
  localparam int CA_DCHUNK = 21;
  localparam int CA_DONE   = 31;

  // control B field positions
  localparam int CB_SDIS     = 0;
  localparam int CB_DDIS     = 1;
  localparam int CB_FLOW_LSB = 2;
  localparam int CB_SFIX     = 4;
  localparam int CB_DFIX     = 5;

  typedef enum logic [1:0] {
    FLOW_M2M = 2'd0,
    FLOW_M2P = 2'd1,
    FLOW_P2M = 2'd2,
    FLOW_P2P = 2'd3
  } flow_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_LOAD, ST_XFER, ST_RD, ST_WR, ST_WBACK
  } st_e;

  function automatic logic [2:0] width_bytes(input logic [1:0] w);
    case (w)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [3:0] lane_mask(input logic [2:0] nb);
    case (nb)
      3'd1:    return 4'b0001;
      3'd2:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  input  logic              hold,
  input  logic [2:0]        nbytes,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst)
      addr <= '0;
    else if (load)
      addr <= load_val;
    else if (step && !hold)
      addr <= addr + ADDR_W'(nbytes);
  end
endmodule

// File: rtl/dma_pack_buf.sv
module dma_pack_buf #(
  parameter int BYTES = 4,
  localparam int FW = $clog2(BYTES + 1),
  localparam int DW = 8 * BYTES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          push,
  input  logic [FW-1:0] push_n,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic [FW-1:0] pop_n,
  output logic [FW-1:0] fill,
  output logic [DW-1:0] head
);
  logic [DW-1:0] store;
  logic [DW-1:0] pmask;

  always_comb begin
    for (int i = 0; i < BYTES; i++)
      pmask[8*i +: 8] = (i < int'(push_n)) ? 8'hFF : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      store <= '0;
      fill  <= '0;
    end else if (pop) begin
      store <= store >> (8 * int'(pop_n));
      fill  <= fill - pop_n;
    end else if (push) begin
      store <= store | ((push_data & pmask) << (8 * int'(fill)));
      fill  <= fill + push_n;
    end
  end

  assign head = store;

  // R3: packing never holds more than the buffer width
  a_r3_fill_bound: assert property (@(posedge clk) disable iff (rst)
    int'(fill) <= BYTES);
  a_r3_push_fits: assert property (@(posedge clk) disable iff (rst)
    push |-> (int'(fill) + int'(push_n) <= BYTES));
endmodule

// File: rtl/dma_chain_channel.sv
module dma_chain_channel
  import dma_chain_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_src,
  input  logic [ADDR_W-1:0] start_dst,
  input  logic [31:0]       start_ctla,
  input  logic [31:0]       start_ctlb,
  input  logic [ADDR_W-1:0] start_dptr,
  input  logic              src_req,
  input  logic              dst_req,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_err,
  output logic              busy,
  output logic              evt_buf_done,
  output logic              evt_chain_done,
  output logic              evt_err
);
  localparam int WB = WORD_W / 8;
  localparam int FW = $clog2(WB + 1);

  st_e               st;
  logic [ADDR_W-1:0] r_sa, r_da, r_nx, dptr;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [WORD_W-1:0] r_ca, r_cb;
  logic [2:0]        widx;
  logic [CNT_W-1:0]  beats_left;
  logic [1:0]        sch, dch;
  logic              r_chain;

  // field decode
  logic [2:0] sb, db;
  logic       s_ch4, d_ch4, s_fix, d_fix, is_last;
  flow_e      flow;
  logic       src_periph, dst_periph, src_go, dst_go;

  assign sb      = width_bytes(r_ca[CA_SW_LSB +: 2]);
  assign db      = width_bytes(r_ca[CA_DW_LSB +: 2]);
  assign s_ch4   = r_ca[CA_SCHUNK];
  assign d_ch4   = r_ca[CA_DCHUNK];
  assign s_fix   = r_cb[CB_SFIX];
  assign d_fix   = r_cb[CB_DFIX];
  assign flow    = flow_e'(r_cb[CB_FLOW_LSB +: 2]);
  assign is_last = r_cb[CB_SDIS] | r_cb[CB_DDIS];

  assign src_periph = (flow == FLOW_P2M) || (flow == FLOW_P2P);
  assign dst_periph = (flow == FLOW_M2P) || (flow == FLOW_P2P);
  assign src_go     = !src_periph || (sch != 2'd0) || src_req;
  assign dst_go     = !dst_periph || (dch != 2'd0) || dst_req;

  logic acc, ld, push, pop;
  assign acc  = mem_req & mem_ready;
  assign ld   = (st == ST_LOAD);
  assign push = (st == ST_RD) & acc & ~mem_err;
  assign pop  = (st == ST_WR) & acc & ~mem_err;

  logic [FW-1:0]     fill;
  logic [WORD_W-1:0] head;
  logic [WORD_W-1:0] rd_elem, wr_data, wb_word;
  logic [3:0]        wr_be;
  logic              need_wr;

  assign rd_elem = mem_rdata >> {src_addr[1:0], 3'b000};
  assign wr_data = head << {dst_addr[1:0], 3'b000};
  assign wr_be   = lane_mask(db) << dst_addr[1:0];
  assign need_wr = int'(fill) >= int'(db);

  always_comb begin
    wb_word = r_ca;
    wb_word[CNT_W-1:0] = beats_left;
    wb_word[CA_DONE] = 1'b1;
  end

  function automatic logic [ADDR_W-1:0] align(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:2], 2'b00};
  endfunction

  dma_addr_gen #(.ADDR_W(ADDR_W)) u_src_addr (
    .clk(clk), .rst(rst), .load(ld), .load_val(r_sa),
    .step(push), .hold(s_fix), .nbytes(sb), .addr(src_addr)
  );

  dma_addr_gen #(.ADDR_W(ADDR_W)) u_dst_addr (
    .clk(clk), .rst(rst), .load(ld), .load_val(r_da),
    .step(pop), .hold(d_fix), .nbytes(db), .addr(dst_addr)
  );

  dma_pack_buf #(.BYTES(WB)) u_pack (
    .clk(clk), .rst(rst), .clear(ld),
    .push(push), .push_n(FW'(sb)), .push_data(rd_elem),
    .pop(pop), .pop_n(FW'(db)),
    .fill(fill), .head(head)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= ST_IDLE;
      r_sa           <= '0;
      r_da           <= '0;
      r_nx           <= '0;
      dptr           <= '0;
      r_ca           <= '0;
      r_cb           <= '0;
      widx           <= '0;
      beats_left     <= '0;
      sch            <= '0;
      dch            <= '0;
      r_chain        <= 1'b0;
      mem_req        <= 1'b0;
      mem_we         <= 1'b0;
      mem_addr       <= '0;
      mem_wdata      <= '0;
      mem_be         <= '0;
      busy           <= 1'b0;
      evt_buf_done   <= 1'b0;
      evt_chain_done <= 1'b0;
      evt_err        <= 1'b0;
    end else begin
      evt_buf_done   <= 1'b0;
      evt_chain_done <= 1'b0;
      evt_err        <= 1'b0;
      if (acc && mem_err) begin
        mem_req <= 1'b0;
        mem_we  <= 1'b0;
        busy    <= 1'b0;
        evt_err <= 1'b1;
        st      <= ST_IDLE;
      end else begin
        case (st)
          ST_IDLE: if (start) begin
            r_sa <= start_src;
            r_da <= start_dst;
            r_ca <= start_ctla;
            r_cb <= start_ctlb;
            dptr <= start_dptr;
            busy <= 1'b1;
            if (start_ctlb[CB_DDIS:CB_SDIS] == 2'b00) begin
              r_chain  <= 1'b1;
              widx     <= '0;
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_be   <= 4'hF;
              mem_addr <= align(start_dptr);
              st       <= ST_FETCH;
            end else begin
              r_chain <= 1'b0;
              st      <= ST_LOAD;
            end
          end
          ST_FETCH: if (acc) begin
            case (widx)
              3'd0:    r_sa <= ADDR_W'(mem_rdata);
              3'd1:    r_da <= ADDR_W'(mem_rdata);
              3'd2:    r_ca <= mem_rdata;
              3'd3:    r_cb <= mem_rdata;
              default: r_nx <= ADDR_W'(mem_rdata);
            endcase
            if (widx == 3'd4) begin
              mem_req <= 1'b0;
              st      <= ST_LOAD;
            end else begin
              widx     <= widx + 3'd1;
              mem_addr <= align(dptr) + ADDR_W'({widx + 3'd1, 2'b00});
            end
          end
          ST_LOAD: begin
            beats_left <= r_ca[CNT_W-1:0];
            sch        <= '0;
            dch        <= '0;
            st         <= ST_XFER;
          end
          ST_XFER: begin
            if (need_wr) begin
              if (dst_go) begin
                mem_req   <= 1'b1;
                mem_we    <= 1'b1;
                mem_addr  <= align(dst_addr);
                mem_wdata <= wr_data;
                mem_be    <= wr_be;
                st        <= ST_WR;
              end
            end else if (beats_left == '0) begin
              if (r_chain) begin
                mem_req   <= 1'b1;
                mem_we    <= 1'b1;
                mem_addr  <= align(dptr) + ADDR_W'(8);
                mem_wdata <= wb_word;
                mem_be    <= 4'hF;
                st        <= ST_WBACK;
              end else begin
                busy           <= 1'b0;
                evt_buf_done   <= 1'b1;
                evt_chain_done <= 1'b1;
                st             <= ST_IDLE;
              end
            end else if (src_go) begin
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= align(src_addr);
              mem_be   <= 4'hF;
              st       <= ST_RD;
            end
          end
          ST_RD: if (acc) begin
            mem_req    <= 1'b0;
            beats_left <= beats_left - CNT_W'(1);
            sch        <= s_ch4 ? sch + 2'd1 : 2'd0;
            st         <= ST_XFER;
          end
          ST_WR: if (acc) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            dch     <= d_ch4 ? dch + 2'd1 : 2'd0;
            st      <= ST_XFER;
          end
          ST_WBACK: if (acc) begin
            mem_we       <= 1'b0;
            evt_buf_done <= 1'b1;
            if (!is_last) begin
              dptr     <= r_nx;
              widx     <= '0;
              mem_req  <= 1'b1;
              mem_be   <= 4'hF;
              mem_addr <= align(r_nx);
              st       <= ST_FETCH;
            end else begin
              mem_req        <= 1'b0;
              busy           <= 1'b0;
              evt_chain_done <= 1'b1;
              st             <= ST_IDLE;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // R10: a pending request holds still until accepted
  a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
  a_r10_req_busy: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);
  // R11: completion leaves the channel idle
  a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
    evt_chain_done |-> (!busy && !mem_req));
  // R9: error abort never reports completion
  a_r9_err_idle: assert property (@(posedge clk) disable iff (rst)
    evt_err |-> (!busy && !evt_chain_done && !mem_req));
  // R3: write strobes cover exactly one element
  a_r3_be_width: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));
  // R8: a peripheral destination chunk waits for its request
  a_r8_dst_wait: assert property (@(posedge clk) disable iff (rst)
    (st == ST_XFER && need_wr && dst_periph && dch == 2'd0 && !dst_req) |=> !mem_req);
endmodule

// File: tb/dma_chain_channel_bench.sv
module dma_chain_channel_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] start_src, start_dst, start_ctla, start_ctlb, start_dptr;
  logic        src_req, dst_req;
  logic        mem_req, mem_we, mem_ready, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        busy, evt_buf_done, evt_chain_done, evt_err;

  always #5 clk = ~clk;

  dma_chain_channel u_dma_chain_channel (
    .clk(clk), .rst(rst), .start(start),
    .start_src(start_src), .start_dst(start_dst),
    .start_ctla(start_ctla), .start_ctlb(start_ctlb), .start_dptr(start_dptr),
    .src_req(src_req), .dst_req(dst_req),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .busy(busy), .evt_buf_done(evt_buf_done),
    .evt_chain_done(evt_chain_done), .evt_err(evt_err)
  );

  // memory model: one wait state on alternate cycles, error above 0x8000
  logic [31:0] mem [0:255];
  logic        phase = 1'b0;
  logic        tb_we = 1'b0;
  logic [31:0] tb_wa = '0, tb_wd = '0;
  int n_rd = 0, n_wr = 0, n_buf = 0, n_chain = 0, n_err = 0;

  assign mem_ready = mem_req & phase;
  assign mem_err   = mem_addr[15];
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    phase <= ~phase;
    if (tb_we) mem[tb_wa[9:2]] <= tb_wd;
    if (mem_req && mem_ready && !mem_err) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        n_wr <= n_wr + 1;
      end else begin
        n_rd <= n_rd + 1;
      end
    end
    if (evt_buf_done)   n_buf   <= n_buf + 1;
    if (evt_chain_done) n_chain <= n_chain + 1;
    if (evt_err)        n_err   <= n_err + 1;
  end

  int nchecks = 0, nfail = 0;
  logic [7:0] exp [0:63];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
  endtask

  function automatic logic [7:0] srcb(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  function automatic logic [7:0] mbyte(input int a);
    return mem[(a >> 2) & 255][8*(a & 3) +: 8];
  endfunction

  function automatic int wbytes(input int w);
    return (w == 0) ? 1 : ((w == 1) ? 2 : 4);
  endfunction

  task automatic poke(input int a, input logic [31:0] d);
    tb_we = 1'b1; tb_wa = a; tb_wd = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic clear_dst();
    for (int i = 0; i < 16; i++) poke(32'h200 + 4*i, 32'h0);
    for (int i = 0; i < 64; i++) exp[i] = 8'h00;
  endtask

  // reference: stream of source bytes placed by destination element rules
  task automatic model(input int sa, input int da, input int sw, input int dw,
                       input bit sfix, input bit dfix, input int cnt);
    int sbn = wbytes(sw);
    int dbn = wbytes(dw);
    for (int k = 0; k < cnt * sbn; k++) begin
      int s = (sfix ? sa : sa + (k / sbn) * sbn) + (k % sbn);
      int d = (dfix ? da : da + (k / dbn) * dbn) + (k % dbn);
      exp[d - 32'h200] = srcb(s);
    end
  endtask

  task automatic cmp_dst(input string tag);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < 64; i++)
      if (mbyte(32'h200 + i) !== exp[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    if (first < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, tag, {24'h0, mbyte(32'h200 + first)}, {24'h0, exp[first]});
  endtask

  task automatic kick(input logic [31:0] sa, input logic [31:0] da, input logic [31:0] ca,
                      input logic [31:0] cb, input logic [31:0] dp);
    start_src = sa; start_dst = da; start_ctla = ca; start_ctlb = cb; start_dptr = dp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int t = 0;
    while (busy && t < 4000) begin
      @(negedge clk);
      t++;
    end
    @(negedge clk);
    chk(t < 4000, tag, t, 4000);
  endtask

  // vector table: [13:12] src width, [11:10] dst width, [9] src fixed, [8] dst fixed, [7:0] count
  localparam logic [13:0] VEC [0:8] = '{
    {2'd0, 2'd0, 1'b0, 1'b0, 8'd5},
    {2'd2, 2'd2, 1'b0, 1'b0, 8'd4},
    {2'd0, 2'd2, 1'b0, 1'b0, 8'd8},
    {2'd2, 2'd0, 1'b0, 1'b0, 8'd3},
    {2'd1, 2'd2, 1'b0, 1'b0, 8'd6},
    {2'd2, 2'd1, 1'b0, 1'b0, 8'd2},
    {2'd0, 2'd0, 1'b1, 1'b0, 8'd4},
    {2'd2, 2'd2, 1'b0, 1'b1, 8'd3},
    {2'd1, 2'd1, 1'b1, 1'b1, 8'd2}
  };

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    int b0, c0, r0, w0, e0;
    rst = 1'b1; start = 1'b0; src_req = 1'b0; dst_req = 1'b0;
    start_src = '0; start_dst = '0; start_ctla = '0; start_ctlb = '0; start_dptr = '0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    @(negedge clk);
    for (int w = 32'h40; w < 32'h50; w++)
      poke(4*w, {srcb(4*w+3), srcb(4*w+2), srcb(4*w+1), srcb(4*w)});
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(!busy, "R1 busy after reset", busy, 0);
    chk(!mem_req && !mem_we, "R1 bus idle after reset", {mem_req, mem_we}, 0);
    chk(!evt_buf_done && !evt_chain_done && !evt_err, "R1 events low after reset",
        {evt_buf_done, evt_chain_done, evt_err}, 0);

    // R2 R3 R4 R5: table of single-buffer memory-to-memory runs
    for (int v = 0; v < 9; v++) begin
      int sw = int'(VEC[v][13:12]);
      int dw = int'(VEC[v][11:10]);
      bit sf = VEC[v][9];
      bit df = VEC[v][8];
      int cn = int'(VEC[v][7:0]);
      clear_dst();
      model(32'h100, 32'h200, sw, dw, sf, df, cn);
      b0 = n_buf; c0 = n_chain;
      kick(32'h100, 32'h200, (sw << 16) | (dw << 18) | cn, 32'h3 | (sf << 4) | (df << 5), 32'h0);
      wait_idle("R2 vector finishes");
      cmp_dst($sformatf("R3 R4 vector %0d data", v));
      chk(n_buf - b0 == 1 && n_chain - c0 == 1, "R2 single events", n_chain - c0, 1);
    end

    // R5 zero length: no data access
    r0 = n_rd; w0 = n_wr; c0 = n_chain;
    kick(32'h100, 32'h200, 32'h000A_0000, 32'h3, 32'h0);
    wait_idle("R5 zero length finishes");
    chk(n_rd == r0 && n_wr == w0, "R5 zero length no access", (n_rd - r0) + (n_wr - w0), 0);
    chk(n_chain - c0 == 1, "R5 zero length completes", n_chain - c0, 1);

    // R6 R7 three-descriptor chain
    clear_dst();
    poke(32'h300, 32'h100); poke(32'h304, 32'h200); poke(32'h308, 32'h000A_0004);
    poke(32'h30C, 32'h0);   poke(32'h310, 32'h320);
    poke(32'h320, 32'h110); poke(32'h324, 32'h210); poke(32'h328, 32'h0000_0008);
    poke(32'h32C, 32'h0);   poke(32'h330, 32'h340);
    poke(32'h340, 32'h120); poke(32'h344, 32'h220); poke(32'h348, 32'h0005_0002);
    poke(32'h34C, 32'h3);   poke(32'h350, 32'h0);
    model(32'h100, 32'h200, 2, 2, 0, 0, 4);
    model(32'h110, 32'h210, 0, 0, 0, 0, 8);
    model(32'h120, 32'h220, 1, 1, 0, 0, 2);
    b0 = n_buf; c0 = n_chain;
    kick(32'h0, 32'h0, 32'h0, 32'h0, 32'h300);
    wait_idle("R6 chain finishes");
    cmp_dst("R6 chain data");
    chk(n_buf - b0 == 3, "R7 buffer pulses per descriptor", n_buf - b0, 3);
    chk(n_chain - c0 == 1, "R11 one chain-done", n_chain - c0, 1);
    chk(mem[32'h308 >> 2] == 32'h800A_0000, "R7 write-back first", mem[32'h308 >> 2], 32'h800A_0000);
    chk(mem[32'h328 >> 2] == 32'h8000_0000, "R7 write-back second", mem[32'h328 >> 2], 32'h8000_0000);
    chk(mem[32'h348 >> 2] == 32'h8005_0000, "R7 write-back last", mem[32'h348 >> 2], 32'h8005_0000);

    // R6 one fetch-disable bit alone ends the chain
    clear_dst();
    poke(32'h308, 32'h000A_0004); poke(32'h30C, 32'h1);
    model(32'h100, 32'h200, 2, 2, 0, 0, 4);
    b0 = n_buf;
    kick(32'h0, 32'h0, 32'h0, 32'h0, 32'h300);
    wait_idle("R6 mixed bits finishes");
    chk(n_buf - b0 == 1, "R6 mixed bits stops after one", n_buf - b0, 1);
    cmp_dst("R6 mixed bits second buffer untouched");

    // R8 memory to peripheral, destination chunk of 4, request withheld
    clear_dst();
    model(32'h100, 32'h200, 0, 0, 0, 0, 8);
    w0 = n_wr;
    kick(32'h100, 32'h200, 32'h0020_0008, 32'h3 | (1 << 2), 32'h0);
    repeat (40) @(negedge clk);
    chk(n_wr == w0 && busy, "R8 destination waits for request", n_wr - w0, 0);
    dst_req = 1'b1;
    wait_idle("R8 m2p finishes");
    dst_req = 1'b0;
    chk(n_wr - w0 == 8, "R8 m2p beat writes", n_wr - w0, 8);
    cmp_dst("R8 m2p data");

    // R8 peripheral to memory, source chunk of 4, request withheld
    clear_dst();
    model(32'h100, 32'h200, 2, 2, 0, 0, 4);
    r0 = n_rd;
    kick(32'h100, 32'h200, 32'h001A_0004, 32'h3 | (2 << 2), 32'h0);
    repeat (40) @(negedge clk);
    chk(n_rd == r0 && busy, "R8 source waits for request", n_rd - r0, 0);
    src_req = 1'b1;
    wait_idle("R8 p2m finishes");
    src_req = 1'b0;
    cmp_dst("R8 p2m data");

    // R9 error on first descriptor fetch
    c0 = n_chain; e0 = n_err;
    kick(32'h0, 32'h0, 32'h0, 32'h0, 32'h8000);
    wait_idle("R9 error ends transfer");
    chk(n_err - e0 == 1, "R9 error pulse", n_err - e0, 1);
    chk(n_chain == c0 && !busy && !mem_req, "R9 no completion after error", n_chain - c0, 0);

    summary();
    $finish;
  end
endmodule